// File: doc/BRIEF.md
# Multicycle Hardwired Processor Controller

This block is the sequencing controller for a multicycle 32-bit load/store processor. It holds a small state register and, from the current state alone, produces every control strobe and multiplexer select the datapath needs: program counter update, memory read and write with address source, instruction register capture, register file write with destination and write-back source, and the two ALU operand selects plus the ALU operation class. The opcode and function fields are taken from the instruction register and only steer which state follows.

Each instruction starts with a shared fetch state and a shared decode state, then walks a class-specific path of one to three further states before returning to fetch. The supported classes are R-format ALU operations, load word, store word, branch-on-equal, jump, and jump-register. Jump-register is an R-format encoding recognised by its function code. It has its own completion state that loads the program counter from the register operand. Control fields that a state does not name are held at 0, so the control word in every cycle is fully defined.

Top module: `mcyc_ctrl_unit`

## Requirements
- R1: Reset is synchronous and active high. While it is sampled high at a rising edge, the state becomes fetch, and the fetch control word appears from that edge onward, including when reset arrives in the middle of an instruction.
- R2: Fetch drives pc_wr=1, mem_rd=1, ir_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00. The next state is always decode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11 and alu_op=00. It dispatches on opcode: 35 (load) and 43 (store) go to the address state, 0 goes to the R-format path, 4 goes to branch, and 2 goes to jump.
- R4: The address state drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. It continues to the load read state for opcode 35 and to the store state for opcode 43.
- R5: Load read drives mem_rd=1 with addr_sel=1. It is followed by load write-back, which drives rf_wr=1 with wb_sel=1 and rf_dst_sel=0 and then returns to fetch.
- R6: The store state drives mem_wr=1 with addr_sel=1 and then returns to fetch.
- R7: The R-format path has two states. Execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. Write-back drives rf_wr=1 with rf_dst_sel=1 and wb_sel=0, then returns to fetch. Once execute is reached, the opcode no longer affects this path.
- R8: Branch drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1 and pc_src=01, then returns to fetch.
- R9: Jump drives pc_wr=1 with pc_src=10, then returns to fetch.
- R10: Opcode 0 with function code 8 goes from decode to the jump-register state. That state drives pc_wr=1 with pc_src=11 and then returns to fetch. Any other function code with opcode 0 takes the R-format path, and the function field has no effect for nonzero opcodes.
- R11: An opcode outside {0, 2, 4, 35, 43} in decode returns the controller to fetch on the next cycle.
- R12: Every control field not named for a state is 0 in that state, and mem_rd and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OP_W (6) | Opcode field from the instruction register |
| funct | input | FN_W (6) | Function field from the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| ir_wr | output | 1 | Instruction register load |
| pc_src | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target, 11 register operand |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 from function field |
| alu_a_sel | output | 1 | ALU input A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write strobe |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |

## Verification
Fetch is the one state where several actions coincide. In the same cycle the program counter is incremented, memory is read at the program counter, and the instruction register captures the result. The bench compares the whole 16-bit control word in every fetch cycle, including the one that starts right after reset is removed mid-instruction, so a fetch that loses any of those three strobes fails the check. A second overlap is in decode, where the same opcode 0 must pick between two paths according to the function field. The bench drives function codes 8, 9 and 0x20 under opcode 0, and 8 under the branch opcode, and checks which completion state follows in each case.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

   localparam int unsigned ST_BITS = 4;

   typedef enum logic [ST_BITS-1:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_MADDR  = 4'd2,
      ST_LDRD   = 4'd3,
      ST_LDWB   = 4'd4,
      ST_STWR   = 4'd5,
      ST_ALUEX  = 4'd6,
      ST_ALUWB  = 4'd7,
      ST_BRCMP  = 4'd8,
      ST_JMP    = 4'd9,
      ST_JREG   = 4'd10
   } mc_state_e;

   // next-PC source select
   localparam logic [1:0] PCS_ALU   = 2'b00;
   localparam logic [1:0] PCS_ALUQ  = 2'b01;
   localparam logic [1:0] PCS_JTGT  = 2'b10;
   localparam logic [1:0] PCS_RSRC  = 2'b11;

   // ALU operation class
   localparam logic [1:0] AOP_ADD   = 2'b00;
   localparam logic [1:0] AOP_SUB   = 2'b01;
   localparam logic [1:0] AOP_FUNC  = 2'b10;

   // ALU operand B select
   localparam logic [1:0] BSEL_REG  = 2'b00;
   localparam logic [1:0] BSEL_FOUR = 2'b01;
   localparam logic [1:0] BSEL_IMM  = 2'b10;
   localparam logic [1:0] BSEL_IMMS = 2'b11;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       addr_sel;
      logic       mem_rd;
      logic       mem_wr;
      logic       wb_sel;
      logic       ir_wr;
      logic [1:0] pc_src;
      logic [1:0] alu_op;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic       rf_wr;
      logic       rf_dst_sel;
   } mc_ctrl_t;

endpackage

// File: rtl/mcyc_state_reg.sv
module mcyc_state_reg
   import mcyc_ctrl_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  mc_state_e nxt,
   output mc_state_e cur
);

   always_ff @(posedge clk) begin
      if (rst) cur <= ST_FETCH;
      else     cur <= nxt;
   end

endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
   import mcyc_ctrl_pkg::*;
#(
   parameter int unsigned OP_W       = 6,
   parameter int unsigned FN_W       = 6,
   parameter int unsigned OP_RTYPE   = 0,
   parameter int unsigned OP_LOAD    = 35,
   parameter int unsigned OP_STORE   = 43,
   parameter int unsigned OP_BEQ     = 4,
   parameter int unsigned OP_JUMP    = 2,
   parameter int unsigned FN_JREG    = 8,
   parameter bit          JR_SUPPORT = 1'b1
)(
   input  mc_state_e       cur,
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] funct,
   output mc_state_e       nxt
);

   localparam logic [OP_W-1:0] C_RTYPE = OP_W'(OP_RTYPE);
   localparam logic [OP_W-1:0] C_LOAD  = OP_W'(OP_LOAD);
   localparam logic [OP_W-1:0] C_STORE = OP_W'(OP_STORE);
   localparam logic [OP_W-1:0] C_BEQ   = OP_W'(OP_BEQ);
   localparam logic [OP_W-1:0] C_JUMP  = OP_W'(OP_JUMP);

   logic is_jreg_fn;
   logic is_mem_op;

   generate
      if (JR_SUPPORT) begin : g_jr_on
         assign is_jreg_fn = (funct == FN_W'(FN_JREG));
      end else begin : g_jr_off
         logic unused_fn;
         assign unused_fn  = ^funct;
         assign is_jreg_fn = 1'b0 & unused_fn;
      end
   endgenerate

   assign is_mem_op = (opcode == C_LOAD) || (opcode == C_STORE);

   always_comb begin
      nxt = ST_FETCH;
      unique case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            if (is_mem_op)              nxt = ST_MADDR;
            else if (opcode == C_RTYPE) nxt = is_jreg_fn ? ST_JREG : ST_ALUEX;
            else if (opcode == C_BEQ)   nxt = ST_BRCMP;
            else if (opcode == C_JUMP)  nxt = ST_JMP;
            else                        nxt = ST_FETCH;
         end
         ST_MADDR:  nxt = (opcode == C_LOAD) ? ST_LDRD : ST_STWR;
         ST_LDRD:   nxt = ST_LDWB;
         ST_ALUEX:  nxt = ST_ALUWB;
         ST_LDWB,
         ST_STWR,
         ST_ALUWB,
         ST_BRCMP,
         ST_JMP,
         ST_JREG:   nxt = ST_FETCH;
         default:   nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcyc_ctrl_decode.sv
module mcyc_ctrl_decode
   import mcyc_ctrl_pkg::*;
(
   input  mc_state_e cur,
   output mc_ctrl_t  ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (cur)
         ST_FETCH: begin
            ctrl.mem_rd    = 1'b1;
            ctrl.ir_wr     = 1'b1;
            ctrl.pc_wr     = 1'b1;
            ctrl.addr_sel  = 1'b0;
            ctrl.alu_a_sel = 1'b0;
            ctrl.alu_b_sel = BSEL_FOUR;
            ctrl.alu_op    = AOP_ADD;
            ctrl.pc_src    = PCS_ALU;
         end
         ST_DECODE: begin
            ctrl.alu_a_sel = 1'b0;
            ctrl.alu_b_sel = BSEL_IMMS;
            ctrl.alu_op    = AOP_ADD;
         end
         ST_MADDR: begin
            ctrl.alu_a_sel = 1'b1;
            ctrl.alu_b_sel = BSEL_IMM;
            ctrl.alu_op    = AOP_ADD;
         end
         ST_LDRD: begin
            ctrl.mem_rd   = 1'b1;
            ctrl.addr_sel = 1'b1;
         end
         ST_LDWB: begin
            ctrl.rf_wr      = 1'b1;
            ctrl.wb_sel     = 1'b1;
            ctrl.rf_dst_sel = 1'b0;
         end
         ST_STWR: begin
            ctrl.mem_wr   = 1'b1;
            ctrl.addr_sel = 1'b1;
         end
         ST_ALUEX: begin
            ctrl.alu_a_sel = 1'b1;
            ctrl.alu_b_sel = BSEL_REG;
            ctrl.alu_op    = AOP_FUNC;
         end
         ST_ALUWB: begin
            ctrl.rf_wr      = 1'b1;
            ctrl.rf_dst_sel = 1'b1;
            ctrl.wb_sel     = 1'b0;
         end
         ST_BRCMP: begin
            ctrl.alu_a_sel  = 1'b1;
            ctrl.alu_b_sel  = BSEL_REG;
            ctrl.alu_op     = AOP_SUB;
            ctrl.pc_wr_cond = 1'b1;
            ctrl.pc_src     = PCS_ALUQ;
         end
         ST_JMP: begin
            ctrl.pc_wr  = 1'b1;
            ctrl.pc_src = PCS_JTGT;
         end
         ST_JREG: begin
            ctrl.pc_wr  = 1'b1;
            ctrl.pc_src = PCS_RSRC;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/mcyc_ctrl_unit.sv
module mcyc_ctrl_unit
   import mcyc_ctrl_pkg::*;
#(
   parameter int unsigned OP_W       = 6,
   parameter int unsigned FN_W       = 6,
   parameter int unsigned OP_RTYPE   = 0,
   parameter int unsigned OP_LOAD    = 35,
   parameter int unsigned OP_STORE   = 43,
   parameter int unsigned OP_BEQ     = 4,
   parameter int unsigned OP_JUMP    = 2,
   parameter int unsigned FN_JREG    = 8,
   parameter bit          JR_SUPPORT = 1'b1
)(
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] funct,
   output logic            pc_wr,
   output logic            pc_wr_cond,
   output logic            addr_sel,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            wb_sel,
   output logic            ir_wr,
   output logic [1:0]      pc_src,
   output logic [1:0]      alu_op,
   output logic            alu_a_sel,
   output logic [1:0]      alu_b_sel,
   output logic            rf_wr,
   output logic            rf_dst_sel
);

   localparam longint unsigned OP_SPAN = 64'd1 << OP_W;
   localparam longint unsigned FN_SPAN = 64'd1 << FN_W;

   // elaboration-time parameter checks
   generate
      if (OP_W < 1 || OP_W > 16) begin : g_bad_opw
         $error("mcyc_ctrl_unit: OP_W out of range");
      end
      if (FN_W < 1 || FN_W > 16) begin : g_bad_fnw
         $error("mcyc_ctrl_unit: FN_W out of range");
      end
      if (OP_RTYPE >= OP_SPAN || OP_LOAD >= OP_SPAN || OP_STORE >= OP_SPAN ||
          OP_BEQ >= OP_SPAN || OP_JUMP >= OP_SPAN) begin : g_bad_opval
         $error("mcyc_ctrl_unit: opcode value does not fit OP_W");
      end
      if (JR_SUPPORT && FN_JREG >= FN_SPAN) begin : g_bad_fnval
         $error("mcyc_ctrl_unit: FN_JREG does not fit FN_W");
      end
      if (OP_LOAD == OP_STORE || OP_RTYPE == OP_BEQ || OP_RTYPE == OP_JUMP ||
          OP_BEQ == OP_JUMP) begin : g_bad_dup
         $error("mcyc_ctrl_unit: opcode values collide");
      end
   endgenerate

   mc_state_e cur_st;
   mc_state_e nxt_st;
   mc_ctrl_t  ctrl;

   mcyc_state_reg u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   mcyc_next_state #(
      .OP_W       (OP_W),
      .FN_W       (FN_W),
      .OP_RTYPE   (OP_RTYPE),
      .OP_LOAD    (OP_LOAD),
      .OP_STORE   (OP_STORE),
      .OP_BEQ     (OP_BEQ),
      .OP_JUMP    (OP_JUMP),
      .FN_JREG    (FN_JREG),
      .JR_SUPPORT (JR_SUPPORT)
   ) u_next (
      .cur    (cur_st),
      .opcode (opcode),
      .funct  (funct),
      .nxt    (nxt_st)
   );

   mcyc_ctrl_decode u_dec (
      .cur  (cur_st),
      .ctrl (ctrl)
   );

   assign pc_wr      = ctrl.pc_wr;
   assign pc_wr_cond = ctrl.pc_wr_cond;
   assign addr_sel   = ctrl.addr_sel;
   assign mem_rd     = ctrl.mem_rd;
   assign mem_wr     = ctrl.mem_wr;
   assign wb_sel     = ctrl.wb_sel;
   assign ir_wr      = ctrl.ir_wr;
   assign pc_src     = ctrl.pc_src;
   assign alu_op     = ctrl.alu_op;
   assign alu_a_sel  = ctrl.alu_a_sel;
   assign alu_b_sel  = ctrl.alu_b_sel;
   assign rf_wr      = ctrl.rf_wr;
   assign rf_dst_sel = ctrl.rf_dst_sel;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk #(
   parameter int unsigned OP_W     = 6,
   parameter int unsigned FN_W     = 6,
   parameter int unsigned OP_RTYPE = 0,
   parameter int unsigned OP_LOAD  = 35,
   parameter int unsigned OP_STORE = 43,
   parameter int unsigned OP_BEQ   = 4,
   parameter int unsigned OP_JUMP  = 2,
   parameter int unsigned FN_JREG  = 8
)(
   input logic            clk,
   input logic            rst,
   input logic [OP_W-1:0] opcode,
   input logic [FN_W-1:0] funct,
   input logic            pc_wr,
   input logic            pc_wr_cond,
   input logic            addr_sel,
   input logic            mem_rd,
   input logic            mem_wr,
   input logic            wb_sel,
   input logic            ir_wr,
   input logic [1:0]      pc_src,
   input logic [1:0]      alu_op,
   input logic            alu_a_sel,
   input logic [1:0]      alu_b_sel,
   input logic            rf_wr,
   input logic            rf_dst_sel
);

   logic in_decode;
   logic op_known;

   assign in_decode = (alu_b_sel == 2'b11) && !alu_a_sel && !ir_wr;
   assign op_known  = (opcode == OP_W'(OP_RTYPE)) || (opcode == OP_W'(OP_LOAD)) ||
                      (opcode == OP_W'(OP_STORE)) || (opcode == OP_W'(OP_BEQ)) ||
                      (opcode == OP_W'(OP_JUMP));

   p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
      ir_wr |=> (alu_b_sel == 2'b11 && !alu_a_sel && !pc_wr && !ir_wr));

   p_load_read_then_wb_r5: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && addr_sel) |=> (rf_wr && wb_sel && !rf_dst_sel));

   p_branch_returns_r8: assert property (@(posedge clk) disable iff (rst)
      pc_wr_cond |=> (ir_wr && pc_wr && mem_rd));

   p_jreg_dispatch_r10: assert property (@(posedge clk) disable iff (rst)
      (in_decode && opcode == OP_W'(OP_RTYPE) && funct == FN_W'(FN_JREG))
      |=> (pc_wr && pc_src == 2'b11 && !ir_wr));

   p_unknown_op_r11: assert property (@(posedge clk) disable iff (rst)
      (in_decode && !op_known) |=> ir_wr);

endmodule

bind mcyc_ctrl_unit mcyc_ctrl_chk #(
   .OP_W     (OP_W),
   .FN_W     (FN_W),
   .OP_RTYPE (OP_RTYPE),
   .OP_LOAD  (OP_LOAD),
   .OP_STORE (OP_STORE),
   .OP_BEQ   (OP_BEQ),
   .OP_JUMP  (OP_JUMP),
   .FN_JREG  (FN_JREG)
) u_chk (.*);

// File: tb/mcyc_ctrl_unit_test.sv
module mcyc_ctrl_unit_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = '0;
   logic [5:0] funct = '0;
   logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, ir_wr;
   logic [1:0] pc_src, alu_op, alu_b_sel;
   logic       alu_a_sel, rf_wr, rf_dst_sel;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   mcyc_ctrl_unit uut (
      .clk (clk), .rst (rst), .opcode (opcode), .funct (funct),
      .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond), .addr_sel (addr_sel),
      .mem_rd (mem_rd), .mem_wr (mem_wr), .wb_sel (wb_sel), .ir_wr (ir_wr),
      .pc_src (pc_src), .alu_op (alu_op), .alu_a_sel (alu_a_sel),
      .alu_b_sel (alu_b_sel), .rf_wr (rf_wr), .rf_dst_sel (rf_dst_sel)
   );

   // word layout: pcw pcwc addr mrd mwr wb ir pcsrc[2] aop[2] asel bsel[2] rfw dst
   function automatic logic [15:0] mk(input logic pcw, input logic pcwc, input logic ad,
                                      input logic mr, input logic mw, input logic wb,
                                      input logic ir, input logic [1:0] ps,
                                      input logic [1:0] ao, input logic aa,
                                      input logic [1:0] bs, input logic rw,
                                      input logic rd);
      return {pcw, pcwc, ad, mr, mw, wb, ir, ps, ao, aa, bs, rw, rd};
   endfunction

   function automatic logic [15:0] exp_word(input int st);
      case (st)
         0:  return mk(1,0,0,1,0,0,1,2'b00,2'b00,0,2'b01,0,0);
         1:  return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
         2:  return mk(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
         3:  return mk(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
         4:  return mk(0,0,0,0,0,1,0,2'b00,2'b00,0,2'b00,1,0);
         5:  return mk(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
         6:  return mk(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
         7:  return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
         8:  return mk(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
         9:  return mk(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);
         10: return mk(1,0,0,0,0,0,0,2'b11,2'b00,0,2'b00,0,0);
         default: return 16'hxxxx;
      endcase
   endfunction

   function automatic logic [15:0] got_word();
      return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_sel, ir_wr,
              pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
   endfunction

   task automatic check_word(input string tag, input int st);
      logic [15:0] g;
      logic [15:0] e;
      g = got_word();
      e = exp_word(st);
      total++;
      if (g !== e) begin
         bad++;
         $display("FAIL %s state %0d: actual=%b expected=%b", tag, st, g, e);
      end
      total++;
      if (mem_rd && mem_wr) begin
         bad++;
         $display("FAIL R12 strobe overlap in %s: actual mem_rd=%b mem_wr=%b expected not both 1",
                  tag, mem_rd, mem_wr);
      end
   endtask

   // starts at a negedge in fetch; ends at a negedge in the final listed state
   task automatic run_seq(input string tag, input logic [5:0] op, input logic [5:0] fn,
                          input int n, input int seq [8]);
      opcode = op;
      funct  = fn;
      for (int i = 0; i < n; i++) begin
         if (i > 0) @(negedge clk);
         check_word(tag, seq[i]);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_word("R1 held reset", 0);
      rst = 1'b0;
      check_word("R1 after release", 0);
   endtask

   task automatic t_rtype();
      run_seq("R7 R3 R2 rtype add", 6'd0, 6'h20, 5, '{0,1,6,7,0,0,0,0});
   endtask

   task automatic t_rtype_op_change();
      // opcode changes after execute is reached: R7 says no effect
      opcode = 6'd0; funct = 6'h22;
      check_word("R7 opchg fetch", 0);
      @(negedge clk); check_word("R7 opchg decode", 1);
      @(negedge clk); check_word("R7 opchg exec", 6);
      opcode = 6'd35;
      @(negedge clk); check_word("R7 opchg wb", 7);
      opcode = 6'd0;
      @(negedge clk); check_word("R7 opchg back", 0);
   endtask

   task automatic t_load();
      run_seq("R4 R5 load", 6'd35, 6'h00, 6, '{0,1,2,3,4,0,0,0});
   endtask

   task automatic t_store();
      run_seq("R4 R6 store", 6'd43, 6'h08, 5, '{0,1,2,5,0,0,0,0});
   endtask

   task automatic t_branch();
      run_seq("R8 branch", 6'd4, 6'h00, 4, '{0,1,8,0,0,0,0,0});
   endtask

   task automatic t_jump();
      run_seq("R9 jump", 6'd2, 6'h3f, 4, '{0,1,9,0,0,0,0,0});
   endtask

   task automatic t_jreg();
      run_seq("R10 jreg", 6'd0, 6'd8, 4, '{0,1,10,0,0,0,0,0});
      run_seq("R10 funct 9 is rtype", 6'd0, 6'd9, 5, '{0,1,6,7,0,0,0,0});
      run_seq("R10 funct 8 under branch", 6'd4, 6'd8, 4, '{0,1,8,0,0,0,0,0});
      run_seq("R10 funct 8 under jump", 6'd2, 6'd8, 4, '{0,1,9,0,0,0,0,0});
   endtask

   task automatic t_unknown();
      run_seq("R11 op 13", 6'd13, 6'd8, 3, '{0,1,0,0,0,0,0,0});
      run_seq("R11 op 63", 6'd63, 6'd0, 3, '{0,1,0,0,0,0,0,0});
      run_seq("R11 op 36", 6'd36, 6'd0, 3, '{0,1,0,0,0,0,0,0});
   endtask

   task automatic t_mid_reset();
      opcode = 6'd35; funct = 6'd0;
      check_word("R1 mid fetch", 0);
      @(negedge clk); check_word("R1 mid decode", 1);
      @(negedge clk); check_word("R1 mid addr", 2);
      rst = 1'b1;
      @(negedge clk); check_word("R1 mid reset to fetch", 0);
      rst = 1'b0;
      @(negedge clk); check_word("R1 mid restart decode", 1);
      @(negedge clk); check_word("R1 mid restart addr", 2);
      @(negedge clk); check_word("R5 mid restart read", 3);
      @(negedge clk); check_word("R5 mid restart wb", 4);
      @(negedge clk); check_word("R5 mid back", 0);
   endtask

   initial begin
      t_reset();
      t_rtype();
      t_rtype_op_change();
      t_load();
      t_store();
      t_branch();
      t_jump();
      t_jreg();
      t_unknown();
      t_mid_reset();
      t_load();
      t_jreg();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule